// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell Array

This block is a synthesizable model of a small programmable logic device. A single configuration vector programs an AND array of product terms. The terms feed a row of output macrocells, and each macrocell ORs its share of the terms, applies a polarity bit, and drives one bidirectional pin. Each pin is modelled as a separate input, output and enable. A global two-bit mode chooses among three kinds of operation:

- **Registered:** cells can hold state in a flip-flop or act as combinational I/O.
- **Complex:** every cell is combinational and has a product-term output enable.
- **Simple:** cells are plain outputs, or they are turned into inputs.

The array is fed from three sources: the dedicated data inputs, two special pins (the clock/data pin and the active-low enable/data pin), and the feedback of every cell. An active-high power-down input freezes the whole device and never enters the logic. All pin outputs and enables are registered. A pin therefore shows the result one clock after the inputs it was computed from.

Top module: `pal_array`

## Requirements
- R1: Array signal k (k=0..NUM_DED-1 are `ded_in[k]`, k=NUM_DED is `aux_pin`, k=NUM_DED+1 is `oe_pin_n`, k=NUM_DED+2+c is the feedback of cell c) gives literal column 2k (true) and 2k+1 (complement). Bit `cfg[(c*NUM_PT+t)*NCOL+col]`=1 puts that literal into term t of cell c. Each term is the AND of its selected literals, and a term that selects no literal evaluates to 1.
- R2: Bit `cfg[TEN_OFS + c*NUM_PT + t]` (with TEN_OFS = NUM_CELL*NUM_PT*NCOL) enables term t of cell c. A term whose enable bit is 0 contributes 0, whatever its literals are.
- R3: Each cell computes f = OR of its sum terms XOR `cfg[POL_OFS+c]` (with POL_OFS = TEN_OFS+NUM_CELL*NUM_PT). Its pin value is the inverse of f.
- R4: The mode is set by two bits. SYN is the last bit of `cfg` and MODE0 is the bit before it. Per-cell select bits sit at `cfg[SEL_OFS+c]` (with SEL_OFS = POL_OFS+NUM_CELL). SYN=0 gives registered mode. SYN=1 with MODE0=1 gives complex mode. SYN=1 with MODE0=0 gives simple mode.
- R5: In registered mode a cell whose select bit is 0 sums all NUM_PT terms into its flip-flop. Its enable is the inverse of `oe_pin_n` from the same edge.
- R6: A cell with select=1 in registered mode, and every cell in complex mode, uses term 0 as its output enable and sums only terms 1..NUM_PT-1.
- R7: In simple mode every term is summed. A cell whose select bit is 1 has its enable held at 0 and acts as an input. The two centre cells (NUM_CELL/2-1 and NUM_CELL/2) are always enabled, whatever their select bit.
- R8: A registered cell feeds its flip-flop value f back into the array, not its pin. Every other cell feeds back its pin level: the driven value while enabled, otherwise `io_in[c]`.
- R9: `aux_pin` and `oe_pin_n` reach the array in every mode.
- R10: While `pdn` is high and `rst` is low, every output and every enable holds its value. Evaluation resumes at the first clock with `pdn` low.
- R11: A synchronous `rst` clears all cell state. After it, every `io_out` bit is 1 and every `io_oe` bit is 0.
- R12: `io_out` and `io_oe` reflect the inputs, configuration and feedback sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pdn | input | 1 | Power-down, active high; freezes the device |
| cfg | input | CFG_W | Configuration vector (AND fuses, term enables, polarity, selects, mode) |
| ded_in | input | NUM_DED | Dedicated data inputs |
| aux_pin | input | 1 | Data value of the clock/data pin |
| oe_pin_n | input | 1 | Enable/data pin; active-low global enable in registered mode |
| io_in | input | NUM_CELL | Level seen on each bidirectional pin |
| io_out | output | NUM_CELL | Value driven on each pin |
| io_oe | output | NUM_CELL | Drive enable for each pin |

## Verification
The bench builds the array with two dedicated inputs, eight cells and eight terms per cell. This keeps the configuration vector small enough to program term by term while leaving the full macrocell count, the centre-cell pair and the full term budget intact. With only two dedicated inputs, every literal of every term can be reached from a short stimulus table. Each configuration exercises one mode. Feedback from registered, enabled and disabled cells is mixed into the same terms, so a wrong feedback source changes the outputs quickly.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    MODE_REG    = 2'd0,
    MODE_CPLX   = 2'd1,
    MODE_SIMPLE = 2'd2
  } pal_mode_e;

  // Number of array signals: dedicated inputs, two special pins, feedbacks.
  function automatic int unsigned sig_count(input int unsigned nded,
                                            input int unsigned ncell);
    return nded + 2 + ncell;
  endfunction

endpackage

// File: rtl/pal_mode_decode.sv
module pal_mode_decode
  import pal_pkg::*;
(
  input  logic      syn_bit,
  input  logic      mode0_bit,
  output pal_mode_e mode
);

  always_comb begin
    if (!syn_bit)       mode = MODE_REG;
    else if (mode0_bit) mode = MODE_CPLX;
    else                mode = MODE_SIMPLE;
  end

endmodule

// File: rtl/pal_term_array.sv
module pal_term_array #(
  parameter int NCOL = 40,
  parameter int NROW = 64
) (
  input  logic [NCOL-1:0]      lits,
  input  logic [NROW*NCOL-1:0] and_fuse,
  input  logic [NROW-1:0]      term_en,
  output logic [NROW-1:0]      prod
);

  // A literal not selected by its fuse is forced to 1 before the AND.
  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign prod[r] = term_en[r] & (&(lits | ~and_fuse[r*NCOL +: NCOL]));
  end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int NUM_PT = 8,
  parameter bit CENTRE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  pal_mode_e         mode,
  input  logic              sel,
  input  logic              pol,
  input  logic [NUM_PT-1:0] terms,
  input  logic              oe_pin_n,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              fb
);

  logic is_reg, term_oe, sop, f_val, oe_next;
  logic state_q, oe_q;

  always_comb begin
    is_reg  = (mode == MODE_REG) && !sel;
    term_oe = ((mode == MODE_REG) && sel) || (mode == MODE_CPLX);
    sop     = term_oe ? (|terms[NUM_PT-1:1]) : (|terms);
    f_val   = sop ^ pol;
    if (is_reg)       oe_next = ~oe_pin_n;
    else if (term_oe) oe_next = terms[0];
    else              oe_next = CENTRE || !sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (!hold) begin
      state_q <= f_val;
      oe_q    <= oe_next;
    end
  end

  assign pin_out = ~state_q;
  assign pin_oe  = oe_q;
  assign fb      = is_reg ? state_q : (oe_q ? ~state_q : pin_in);

endmodule

// File: rtl/pal_array.sv
module pal_array
  import pal_pkg::*;
#(
  parameter int NUM_DED  = 10,
  parameter int NUM_CELL = 8,
  parameter int NUM_PT   = 8,
  localparam int NSIG    = sig_count(NUM_DED, NUM_CELL),
  localparam int NCOL    = 2 * NSIG,
  localparam int NROW    = NUM_CELL * NUM_PT,
  localparam int TEN_OFS = NROW * NCOL,
  localparam int POL_OFS = TEN_OFS + NROW,
  localparam int SEL_OFS = POL_OFS + NUM_CELL,
  localparam int M0_BIT  = SEL_OFS + NUM_CELL,
  localparam int SYN_BIT = M0_BIT + 1,
  localparam int CFG_W   = SYN_BIT + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pdn,
  input  logic [CFG_W-1:0]    cfg,
  input  logic [NUM_DED-1:0]  ded_in,
  input  logic                aux_pin,
  input  logic                oe_pin_n,
  input  logic [NUM_CELL-1:0] io_in,
  output logic [NUM_CELL-1:0] io_out,
  output logic [NUM_CELL-1:0] io_oe
);

  pal_mode_e             mode;
  logic [NUM_CELL-1:0]   fb;
  logic [NSIG-1:0]       sig;
  logic [NCOL-1:0]       lits;
  logic [NROW-1:0]       prod;
  logic [NUM_CELL-1:0]   sel_bits;
  logic [NUM_CELL-1:0]   pol_bits;
  logic                  syn_bit, mode0_bit;

  assign syn_bit   = cfg[SYN_BIT];
  assign mode0_bit = cfg[M0_BIT];
  assign sel_bits  = cfg[SEL_OFS +: NUM_CELL];
  assign pol_bits  = cfg[POL_OFS +: NUM_CELL];

  pal_mode_decode u_mode (
    .syn_bit  (syn_bit),
    .mode0_bit(mode0_bit),
    .mode     (mode)
  );

  assign sig = {fb, oe_pin_n, aux_pin, ded_in};

  for (genvar k = 0; k < NSIG; k++) begin : g_lit
    assign lits[2*k]   = sig[k];
    assign lits[2*k+1] = ~sig[k];
  end

  pal_term_array #(
    .NCOL(NCOL),
    .NROW(NROW)
  ) u_terms (
    .lits    (lits),
    .and_fuse(cfg[TEN_OFS-1:0]),
    .term_en (cfg[TEN_OFS +: NROW]),
    .prod    (prod)
  );

  for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell
    pal_macrocell #(
      .NUM_PT(NUM_PT),
      .CENTRE((c == NUM_CELL/2 - 1) || (c == NUM_CELL/2))
    ) u_mc (
      .clk     (clk),
      .rst     (rst),
      .hold    (pdn),
      .mode    (mode),
      .sel     (sel_bits[c]),
      .pol     (pol_bits[c]),
      .terms   (prod[c*NUM_PT +: NUM_PT]),
      .oe_pin_n(oe_pin_n),
      .pin_in  (io_in[c]),
      .pin_out (io_out[c]),
      .pin_oe  (io_oe[c]),
      .fb      (fb[c])
    );
  end

endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
  parameter int NUM_CELL = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                pdn,
  input logic                oe_pin_n,
  input logic                syn_bit,
  input logic                mode0_bit,
  input logic [NUM_CELL-1:0] sel_bits,
  input logic [NUM_CELL-1:0] io_out,
  input logic [NUM_CELL-1:0] io_oe
);

  localparam int CLO = NUM_CELL/2 - 1;
  localparam int CHI = NUM_CELL/2;

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((&io_out) && (io_oe == '0)));

  assert_powerdown_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pdn && !rst) |=> ($stable(io_out) && $stable(io_oe)));

  assert_centre_out_R7: assert property (@(posedge clk) disable iff (rst)
    (!pdn && syn_bit && !mode0_bit) |=> (io_oe[CLO] && io_oe[CHI]));

  for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell
    assert_global_oe_R5: assert property (@(posedge clk) disable iff (rst)
      (!pdn && !syn_bit && !sel_bits[c]) |=> (io_oe[c] == !$past(oe_pin_n)));
    if (c != CLO && c != CHI) begin : g_edge
      assert_input_cell_R7: assert property (@(posedge clk) disable iff (rst)
        (!pdn && syn_bit && !mode0_bit && sel_bits[c]) |=> !io_oe[c]);
    end
  end

endmodule

bind pal_array pal_array_chk #(.NUM_CELL(NUM_CELL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pdn      (pdn),
  .oe_pin_n (oe_pin_n),
  .syn_bit  (syn_bit),
  .mode0_bit(mode0_bit),
  .sel_bits (sel_bits),
  .io_out   (io_out),
  .io_oe    (io_oe)
);

// File: tb/sim_pal_array.sv
module sim_pal_array;

  localparam int NUM_DED  = 2;
  localparam int NUM_CELL = 8;
  localparam int NUM_PT   = 8;
  localparam int NSIG     = NUM_DED + 2 + NUM_CELL;
  localparam int NCOL     = 2 * NSIG;
  localparam int NROW     = NUM_CELL * NUM_PT;
  localparam int TEN      = NROW * NCOL;
  localparam int POL      = TEN + NROW;
  localparam int SEL      = POL + NUM_CELL;
  localparam int M0       = SEL + NUM_CELL;
  localparam int SYN      = M0 + 1;
  localparam int CFG_W    = SYN + 1;
  localparam int S_D0 = 0, S_D1 = 1, S_AUX = NUM_DED, S_OEN = NUM_DED + 1, S_FB = NUM_DED + 2;

  // {ded_in[1:0], aux_pin, oe_pin_n, io_in[7:0]}
  localparam logic [11:0] STIM [16] = '{
    12'h5A3, 12'h0FF, 12'hC3C, 12'h812, 12'h277, 12'hE01, 12'h49A, 12'hB6D,
    12'h300, 12'hD55, 12'h6E8, 12'h1C4, 12'hAAA, 12'hF3F, 12'h706, 12'h9B1
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                pdn = 1'b0;
  logic [CFG_W-1:0]    cfg = '0;
  logic [NUM_DED-1:0]  ded = '0;
  logic                aux = 1'b0;
  logic                oen = 1'b1;
  logic [NUM_CELL-1:0] io_in = '0;
  logic [NUM_CELL-1:0] io_out, io_oe;
  logic [NUM_CELL-1:0] m_r = '0, m_oe = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pal_array #(.NUM_DED(NUM_DED), .NUM_CELL(NUM_CELL), .NUM_PT(NUM_PT)) u0 (
    .clk(clk), .rst(rst), .pdn(pdn), .cfg(cfg), .ded_in(ded), .aux_pin(aux),
    .oe_pin_n(oen), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic lit(input int c, input int t, input int k, input int neg);
    cfg[(c*NUM_PT + t)*NCOL + 2*k + neg] = 1'b1;
  endtask

  task automatic ten(input int c, input int t);
    cfg[TEN + c*NUM_PT + t] = 1'b1;
  endtask

  function automatic logic term_val(input int c, input int t, input logic [NCOL-1:0] l);
    logic v = cfg[TEN + c*NUM_PT + t];
    for (int col = 0; col < NCOL; col++)
      if (cfg[(c*NUM_PT + t)*NCOL + col] && !l[col]) v = 1'b0;
    return v;
  endfunction

  // Reference: next cell state and enable from the requirements.
  task automatic model_step();
    logic [NSIG-1:0] s;
    logic [NCOL-1:0] l;
    logic [NUM_CELL-1:0] nr, noe;
    logic syn = cfg[SYN], m0 = cfg[M0];
    s[S_D0 +: NUM_DED] = ded;
    s[S_AUX] = aux;
    s[S_OEN] = oen;
    for (int c = 0; c < NUM_CELL; c++) begin
      if (!syn && !cfg[SEL+c]) s[S_FB+c] = m_r[c];
      else s[S_FB+c] = m_oe[c] ? ~m_r[c] : io_in[c];
    end
    for (int k = 0; k < NSIG; k++) begin
      l[2*k] = s[k];
      l[2*k+1] = ~s[k];
    end
    for (int c = 0; c < NUM_CELL; c++) begin
      logic rg = !syn && !cfg[SEL+c];
      logic po = (!syn && cfg[SEL+c]) || (syn && m0);
      logic sum = 1'b0;
      for (int t = po ? 1 : 0; t < NUM_PT; t++) sum |= term_val(c, t, l);
      nr[c] = sum ^ cfg[POL+c];
      if (rg) noe[c] = !oen;
      else if (po) noe[c] = term_val(c, 0, l);
      else noe[c] = (c == NUM_CELL/2-1) || (c == NUM_CELL/2) || !cfg[SEL+c];
    end
    m_r = nr;
    m_oe = noe;
  endtask

  task automatic step(input logic [11:0] v, input logic pd);
    {ded, aux, oen, io_in} = v;
    pdn = pd;
    if (!pd) model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_table(input string tag);
    for (int i = 0; i < 16; i++) begin
      step(STIM[i], 1'b0);
      chk({tag, " out"}, io_out, ~m_r);
      chk({tag, " oe"}, io_oe, m_oe);
    end
  endtask

  task automatic cfg_registered();
    cfg = '0;
    cfg[M0] = 1'b1;
    lit(0, 0, S_D0, 0); lit(0, 0, S_D1, 1); ten(0, 0);
    lit(0, 1, S_AUX, 0); ten(0, 1); cfg[POL+0] = 1'b1;
    lit(1, 0, S_FB+1, 1); ten(1, 0);
    cfg[SEL+2] = 1'b1; lit(2, 0, S_D1, 0); ten(2, 0);
    lit(2, 1, S_FB+0, 0); ten(2, 1);
    lit(2, 2, S_FB+1, 0); lit(2, 2, S_AUX, 0); ten(2, 2);
    ten(3, 0);
    cfg[SEL+4] = 1'b1; ten(4, 0); lit(4, 1, S_OEN, 0); ten(4, 1);
    lit(4, 2, S_D0, 1); lit(4, 2, S_FB+6, 0); ten(4, 2);
    lit(5, 0, S_FB+6, 0); ten(5, 0);
    lit(5, 1, S_FB+4, 0); lit(5, 1, S_AUX, 1); ten(5, 1);
    cfg[SEL+6] = 1'b1;
  endtask

  task automatic cfg_complex();
    cfg = '0;
    cfg[SYN] = 1'b1; cfg[M0] = 1'b1;
    for (int c = 0; c < NUM_CELL; c++) begin
      ten(c, 0);
      if (c % 2 == 0) lit(c, 0, S_D0, 0);
      lit(c, 1, S_AUX, 0); lit(c, 1, S_FB + (c+1)%NUM_CELL, 0); ten(c, 1);
      lit(c, 2, S_OEN, 1); lit(c, 2, S_FB + c, 1); ten(c, 2);
      cfg[POL+c] = c[0];
    end
  endtask

  task automatic cfg_simple();
    cfg = '0;
    cfg[SYN] = 1'b1;
    for (int c = 0; c < NUM_CELL; c++) begin
      cfg[SEL+c] = 1'b1;
      lit(c, 0, S_D0, 0); lit(c, 0, S_FB + (c+7)%NUM_CELL, 0); ten(c, 0);
      lit(c, 7, S_AUX, 1); ten(c, 7);
    end
    cfg[POL+3] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held_o, held_e;
    repeat (2) @(negedge clk);
    chk("R11 reset out", io_out, 8'hFF);
    chk("R11 reset oe", io_oe, 8'h00);
    rst = 1'b0;

    cfg_registered();
    run_table("R4 R5 R6 R8 R9 R12 registered");
    chk("R1 empty term", {7'd0, io_out[3]}, 8'd0);
    chk("R2 disabled term", {7'd0, io_out[7]}, 8'd1);

    held_o = io_out;
    held_e = io_oe;
    for (int i = 0; i < 3; i++) begin
      step(STIM[i*5+1], 1'b1);
      chk("R10 hold out", io_out, held_o);
      chk("R10 hold oe", io_oe, held_e);
    end
    step(STIM[3], 1'b0);
    chk("R10 resume out", io_out, ~m_r);
    chk("R10 resume oe", io_oe, m_oe);

    cfg_complex();
    run_table("R3 R4 R6 R8 R9 complex");

    cfg_simple();
    run_table("R4 R7 R8 simple");
    chk("R7 centre enables", io_oe, 8'h18);

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 mid reset out", io_out, 8'hFF);
    chk("R11 mid reset oe", io_oe, 8'h00);
    m_r = '0;
    m_oe = '0;
    rst = 1'b0;
    step(STIM[7], 1'b0);
    chk("R12 after reset out", io_out, ~m_r);
    chk("R12 after reset oe", io_oe, m_oe);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule